// File: doc/BRIEF.md
# Supervisor Watchdog and Reset Generator

This block produces the system reset for a small microcontroller supervisor. Reset is held for a fixed stretch of clock cycles once the power-on indication releases, and it is forced again whenever a digital low-supply flag is raised. After the flag clears, reset stays asserted for the same stretch before it releases. Both polarities of reset are driven from one register.

While reset is released, a watchdog counts clock cycles. Firmware restarts the count by producing a falling edge on the shared chip-select / watchdog-input pin, which is sampled through a two-flop synchroniser. The timeout length comes from a two-bit select field held in a persistent register outside the block. Three codes pick a preset length and the fourth code turns the watchdog off. An expired watchdog raises reset through the same stretch logic that serves power-on and low-supply events. All pins are plain level signals with no handshake.

Top module: `supv_reset_gen`

## Requirements
- R1: While `pwr_on_n` is low, `sys_rst` is 1 and `sys_rst_n` is 0 without waiting for a clock edge, and `sys_rst_n` is always the complement of `sys_rst`.
- R2: After `pwr_on_n` rises, `sys_rst` stays 1 through the first HOLD_CYC-1 rising clock edges and falls at the HOLD_CYC-th edge.
- R3: A high `low_vdd` sampled at a clock edge sets `sys_rst` at that edge. Reset falls HOLD_CYC edges after the last edge that sampled `low_vdd` high.
- R4: With no restart, reset rises at the L-th edge after it fell, where L is WDT_T0 for select 2'b00, WDT_T1 for 2'b01 and WDT_T2 for 2'b10.
- R5: Select code 2'b11 disables the watchdog, so reset never rises from a timeout. The count is held at zero, so after re-enabling, a full L cycles pass before expiry.
- R6: A falling edge of `cs_wdi` driven just after edge k clears the watchdog count at edge k+3, and the L-cycle timeout restarts from there. A rising edge has no effect.
- R7: While reset is asserted, the watchdog count is held at zero and edges on `cs_wdi` have no effect.
- R8: A restart that clears the count at the same edge where the count would expire takes priority, and reset does not rise.
- R9: A watchdog expiry asserts reset for HOLD_CYC edges, the same stretch used for power-on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Supervisor clock |
| pwr_on_n | input | 1 | Power-on indication, low while power is being applied (asynchronous) |
| low_vdd | input | 1 | Low-supply flag, high while the supply is below its trip point |
| cs_wdi | input | 1 | Shared chip-select / watchdog-input pin, a falling edge restarts the watchdog |
| wdt_sel | input | 2 | Timeout select from the persistent register: 00, 01, 10 presets, 11 off |
| sys_rst | output | 1 | Active-high system reset |
| sys_rst_n | output | 1 | Active-low system reset |

## Verification
Two events can land on the same clock edge. A watchdog restart can arrive exactly at the edge where the count reaches its limit. A low-supply flag can also rise at the very edge where the watchdog expires. The first case is provoked by sweeping the restart offset across every cycle of each timeout. The expected time to the next reset is computed as either the plain timeout or offset plus synchroniser latency plus timeout, and the offset at the boundary must give the longer value. The second case raises the flag one cycle before expiry. It is judged by checking that reset is high at that edge and that the release comes a full stretch after the flag drops, not after the expiry.

// File: rtl/supv_pkg.sv
package supv_pkg;
  typedef enum logic [1:0] {
    WDT_SHORT = 2'b00,
    WDT_MID   = 2'b01,
    WDT_LONG  = 2'b10,
    WDT_OFF   = 2'b11
  } wdt_sel_e;

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/wdi_edge_sync.sv
module wdi_edge_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic pwr_on_n,
  input  logic pin_in,
  output logic fall_pulse
);
  localparam int unsigned DEPTH = SYNC_STAGES + 1;

  logic [DEPTH-1:0] shreg;

  always_ff @(posedge clk or negedge pwr_on_n) begin
    if (!pwr_on_n) shreg <= '1;
    else           shreg <= {shreg[DEPTH-2:0], pin_in};
  end

  // older sample high, newer sample low: a falling edge past the synchroniser
  assign fall_pulse = shreg[DEPTH-1] & ~shreg[DEPTH-2];
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import supv_pkg::*;
#(
  parameter int unsigned WDT_T0 = 8,
  parameter int unsigned WDT_T1 = 12,
  parameter int unsigned WDT_T2 = 16,
  parameter int unsigned CNT_W  = 5
) (
  input  logic             clk,
  input  logic             pwr_on_n,
  input  logic             hold,
  input  logic             kick,
  input  wdt_sel_e         sel,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  logic [CNT_W-1:0] limit;
  logic             enabled;

  always_comb begin
    enabled = 1'b1;
    unique case (sel)
      WDT_SHORT: limit = CNT_W'(WDT_T0);
      WDT_MID:   limit = CNT_W'(WDT_T1);
      WDT_LONG:  limit = CNT_W'(WDT_T2);
      default: begin
        limit   = '0;
        enabled = 1'b0;
      end
    endcase
  end

  // >= keeps a shortened select from letting the count run past its limit
  assign expire = enabled && !hold && !kick && (cnt >= (limit - 1'b1));

  always_ff @(posedge clk or negedge pwr_on_n) begin
    if (!pwr_on_n)                       cnt <= '0;
    else if (hold || kick || !enabled)   cnt <= '0;
    else if (expire)                     cnt <= '0;
    else                                 cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/reset_stretch.sv
module reset_stretch #(
  parameter int unsigned HOLD_CYC = 6,
  parameter int unsigned HOLD_W   = 3
) (
  input  logic              clk,
  input  logic              pwr_on_n,
  input  logic              trig,
  output logic              rst_q,
  output logic [HOLD_W-1:0] hold_cnt
);
  always_ff @(posedge clk or negedge pwr_on_n) begin
    if (!pwr_on_n) begin
      rst_q    <= 1'b1;
      hold_cnt <= '0;
    end else if (trig) begin
      rst_q    <= 1'b1;
      hold_cnt <= '0;
    end else if (rst_q) begin
      if (hold_cnt == HOLD_W'(HOLD_CYC - 1)) begin
        rst_q    <= 1'b0;
        hold_cnt <= '0;
      end else begin
        hold_cnt <= hold_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/supv_reset_gen.sv
module supv_reset_gen
  import supv_pkg::*;
#(
  parameter int unsigned HOLD_CYC    = 6,
  parameter int unsigned WDT_T0      = 8,
  parameter int unsigned WDT_T1      = 12,
  parameter int unsigned WDT_T2      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       pwr_on_n,
  input  logic       low_vdd,
  input  logic       cs_wdi,
  input  logic [1:0] wdt_sel,
  output logic       sys_rst,
  output logic       sys_rst_n
);
  localparam int unsigned T_MAX  = max3(WDT_T0, WDT_T1, WDT_T2);
  localparam int unsigned CNT_W  = $clog2(T_MAX + 1);
  localparam int unsigned HOLD_W = (HOLD_CYC > 2) ? $clog2(HOLD_CYC) : 1;

  logic              kick;
  logic              expire;
  logic              rst_q;
  logic [CNT_W-1:0]  wdt_cnt;
  logic [HOLD_W-1:0] hold_cnt;

  wdi_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .pwr_on_n   (pwr_on_n),
    .pin_in     (cs_wdi),
    .fall_pulse (kick)
  );

  wdt_counter #(
    .WDT_T0 (WDT_T0),
    .WDT_T1 (WDT_T1),
    .WDT_T2 (WDT_T2),
    .CNT_W  (CNT_W)
  ) u_wdt (
    .clk      (clk),
    .pwr_on_n (pwr_on_n),
    .hold     (rst_q),
    .kick     (kick),
    .sel      (wdt_sel_e'(wdt_sel)),
    .cnt      (wdt_cnt),
    .expire   (expire)
  );

  reset_stretch #(.HOLD_CYC(HOLD_CYC), .HOLD_W(HOLD_W)) u_stretch (
    .clk      (clk),
    .pwr_on_n (pwr_on_n),
    .trig     (low_vdd | expire),
    .rst_q    (rst_q),
    .hold_cnt (hold_cnt)
  );

  assign sys_rst   = rst_q;
  assign sys_rst_n = ~rst_q;
endmodule

// File: rtl/supv_reset_gen_chk.sv
module supv_reset_gen_chk #(
  parameter int unsigned HOLD_CYC = 6,
  parameter int unsigned CNT_W    = 5,
  parameter int unsigned HOLD_W   = 3
) (
  input logic              clk,
  input logic              pwr_on_n,
  input logic              low_vdd,
  input logic [1:0]        wdt_sel,
  input logic              kick,
  input logic              sys_rst,
  input logic [CNT_W-1:0]  wdt_cnt,
  input logic [HOLD_W-1:0] hold_cnt
);
  p_low_forces_r3: assert property (@(posedge clk) disable iff (!pwr_on_n)
    low_vdd |=> sys_rst);

  p_cnt_held_r7: assert property (@(posedge clk) disable iff (!pwr_on_n)
    sys_rst |=> (wdt_cnt == '0));

  p_off_no_timeout_r5: assert property (@(posedge clk) disable iff (!pwr_on_n)
    (!sys_rst && !low_vdd && wdt_sel == 2'b11) |=> !sys_rst);

  p_kick_restart_r6: assert property (@(posedge clk) disable iff (!pwr_on_n)
    (kick && !sys_rst) |=> (wdt_cnt == '0));

  p_release_after_stretch_r2: assert property (@(posedge clk) disable iff (!pwr_on_n)
    $fell(sys_rst) |-> ($past(hold_cnt) == HOLD_W'(HOLD_CYC - 1)));

  p_stretch_bound_r9: assert property (@(posedge clk) disable iff (!pwr_on_n)
    hold_cnt <= HOLD_W'(HOLD_CYC - 1));
endmodule

bind supv_reset_gen supv_reset_gen_chk #(
  .HOLD_CYC (HOLD_CYC),
  .CNT_W    (CNT_W),
  .HOLD_W   (HOLD_W)
) u_chk (
  .clk      (clk),
  .pwr_on_n (pwr_on_n),
  .low_vdd  (low_vdd),
  .wdt_sel  (wdt_sel),
  .kick     (kick),
  .sys_rst  (sys_rst),
  .wdt_cnt  (wdt_cnt),
  .hold_cnt (hold_cnt)
);

// File: tb/supv_reset_gen_bench.sv
`timescale 1ns/1ps
module supv_reset_gen_bench;
  localparam int HOLD = 6;
  localparam int T0 = 8;
  localparam int T1 = 12;
  localparam int T2 = 16;

  logic       clk = 1'b0;
  logic       pwr_on_n = 1'b0;
  logic       low_vdd = 1'b0;
  logic       cs_wdi = 1'b1;
  logic [1:0] wdt_sel = 2'b00;
  logic       sys_rst;
  logic       sys_rst_n;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  supv_reset_gen #(
    .HOLD_CYC (HOLD),
    .WDT_T0   (T0),
    .WDT_T1   (T1),
    .WDT_T2   (T2)
  ) u_supv_reset_gen (
    .clk       (clk),
    .pwr_on_n  (pwr_on_n),
    .low_vdd   (low_vdd),
    .cs_wdi    (cs_wdi),
    .wdt_sel   (wdt_sel),
    .sys_rst   (sys_rst),
    .sys_rst_n (sys_rst_n)
  );

  function automatic int lim(int s);
    return (s == 0) ? T0 : (s == 1) ? T1 : T2;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // counts rising edges until sys_rst equals lvl, sampling 1 ns after each edge
  task automatic count_till(input logic lvl, output int n);
    n = 0;
    do begin
      @(posedge clk); #1;
      n++;
    end while (sys_rst != lvl && n < 1000);
  endtask

  // starts just after reset fell; restart pulse on cs_wdi driven after edge j
  task automatic trial(int s, int j, int next_s);
    int L, c, e, n;
    L = lim(s);
    e = (j <= L - 3) ? (j + 3 + L) : L;
    c = 0;
    while (1) begin
      @(posedge clk); #1;
      c++;
      if (sys_rst || c > 200) break;
      if (c == j)     cs_wdi = 1'b0;
      if (c == j + 2) cs_wdi = 1'b1;
    end
    if (j == L - 3)     check(c == e, "R8", c, e);
    else if (j < L - 3) check(c == e, "R6", c, e);
    else                check(c == e, "R4", c, e);
    cs_wdi  = 1'b1;
    wdt_sel = 2'(next_s);
    count_till(1'b0, n);
    check(n == HOLD, "R9", n, HOLD);
    check(sys_rst_n == ~sys_rst, "R1", sys_rst_n, ~sys_rst);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n, c, highs;
    // R1: reset state while power-on indication is low
    repeat (3) @(posedge clk);
    #1;
    check(sys_rst == 1'b1 && sys_rst_n == 1'b0, "R1", {sys_rst, sys_rst_n}, 2'b10);

    // R2: power-on stretch
    @(negedge clk);
    pwr_on_n = 1'b1;
    count_till(1'b0, n);
    check(n == HOLD, "R2", n, HOLD);

    // R4 R6 R8 R9: restart offset swept over every preset
    for (int s = 0; s < 3; s++) begin
      for (int j = 1; j <= lim(s) + 1; j++) begin
        int nx;
        nx = (j == lim(s) + 1) ? ((s + 1) % 3) : s;
        trial(s, j, nx);
      end
    end

    // R6 R7: edge on cs_wdi during stretch ignored, then a rising edge only
    wdt_sel = 2'b00;
    @(posedge clk); #1;
    c = 0;
    while (1) begin
      @(posedge clk); #1;
      c++;
      if (sys_rst || c > 200) break;
    end
    cs_wdi = 1'b0;
    count_till(1'b0, n);
    check(n == HOLD, "R7", n, HOLD);
    c = 0;
    while (1) begin
      @(posedge clk); #1;
      c++;
      if (sys_rst || c > 200) break;
      if (c == 2) cs_wdi = 1'b1;
    end
    check(c == T0, "R6", c, T0);
    count_till(1'b0, n);

    // R3 R8: low-supply flag raised on the expiry edge
    c = 0;
    while (1) begin
      @(posedge clk); #1;
      c++;
      if (c == T0 - 1) low_vdd = 1'b1;
      if (c == T0) check(sys_rst == 1'b1, "R3", sys_rst, 1);
      if (c == T0 + 2) break;
    end
    low_vdd = 1'b0;
    count_till(1'b0, n);
    check(n == HOLD, "R3", n, HOLD);

    // R3: flag pulse mid-run
    repeat (3) @(posedge clk);
    #1;
    low_vdd = 1'b1;
    @(posedge clk); #1;
    low_vdd = 1'b0;
    check(sys_rst == 1'b1 && sys_rst_n == 1'b0, "R3", sys_rst, 1);
    count_till(1'b0, n);
    check(n == HOLD, "R3", n, HOLD);

    // R5: watchdog off, then full timeout after re-enable
    wdt_sel = 2'b11;
    highs = 0;
    repeat (100) begin
      @(posedge clk); #1;
      if (sys_rst) highs++;
    end
    check(highs == 0, "R5", highs, 0);
    wdt_sel = 2'b00;
    count_till(1'b1, n);
    check(n == T0, "R5", n, T0);
    count_till(1'b0, n);

    // R1: asynchronous assertion by the power-on indication
    @(negedge clk);
    #0.5;
    pwr_on_n = 1'b0;
    #0.5;
    check(sys_rst == 1'b1 && sys_rst_n == 1'b0, "R1", {sys_rst, sys_rst_n}, 2'b10);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule